// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block receives asynchronous serial frames on a single line and returns each data word together with a parity-error flag and a framing-error flag. The word is delivered with a valid strobe that lasts one clock. The frame format is chosen at run time through configuration inputs: a data length of 5 to 9 bits, one of five parity modes, four stop lengths (half, one, one-and-a-half or two bit periods), least- or most-significant-bit-first order, and two kinds of inversion. Whole-line inversion flips every level. Data-only inversion flips just the data and parity bits.

The bit timing comes from a clocks-per-bit divisor. The line first passes through a two-flop synchroniser. A falling edge on the idle line starts a frame. The start bit is checked again at its centre, so a short low glitch is dropped. Every later bit is sampled at the centre of its period. Once the final stop bit has been sampled, the receiver waits until the full stop duration has passed and only then looks for the next start bit. A frame that follows with no idle gap is still caught.

The configuration is expected to change only while the line is idle. The divisor is expected to be at least 4.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, rx_valid, rx_parity_err and rx_frame_err are 0 and rx_word is all zeros.
- R2: With cfg_msb_first=0 the first data bit after the start bit lands in rx_word[0]. cfg_data_len (5 to 9) sets the number of data bits. rx_word bits at and above the data length are 0.
- R3: With cfg_msb_first=1 the first data bit after the start bit lands in rx_word[len-1] and the last one lands in rx_word[0].
- R4: cfg_parity=1 (odd) and cfg_parity=2 (even) expect one parity bit after the last data bit. rx_parity_err is 1 with the word when the number of ones over the data bits and the parity bit is not odd (odd mode) or not even (even mode).
- R5: cfg_parity=3 (mark) expects a parity bit of 1 and cfg_parity=4 (space) expects 0. A mismatch sets rx_parity_err. cfg_parity=0 (none) has no parity bit slot, and rx_parity_err is then always 0. Codes 5 to 7 behave as none.
- R6: cfg_stop selects the stop length: 0 = half, 1 = one, 2 = one and a half, 3 = two bit periods. No start bit is looked for until the full stop duration has passed. A start bit that begins exactly when it ends is received.
- R7: rx_frame_err is 1 with the word when any stop bit is sampled low (after line inversion is removed). In two-stop mode this applies to either stop bit.
- R8: With cfg_line_inv=1 every line level is complemented. The idle level is low, the start bit is high, and words and flags are the same as for the non-inverted frame.
- R9: With cfg_data_inv=1 the data and parity bits are complemented before use, while the start and stop bits are read at their normal levels.
- R10: A start-level pulse shorter than half a bit period, with the line back at idle at the start-bit centre, produces no rx_valid. The next proper frame is received normally.
- R11: rx_valid is high for exactly one cycle per frame, shortly after the centre of the final stop bit. rx_word, rx_parity_err and rx_frame_err change only with rx_valid and hold their values until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input |
| cfg_clks_per_bit | input | CPB_W | Clock cycles per bit period (at least 4) |
| cfg_data_len | input | 4 | Data bits per frame, 5 to 9; other values are clamped into that range |
| cfg_parity | input | 3 | 0 none, 1 odd, 2 even, 3 mark, 4 space |
| cfg_stop | input | 2 | 0 half, 1 one, 2 one and a half, 3 two bit periods |
| cfg_msb_first | input | 1 | 1: most significant data bit is sent first |
| cfg_line_inv | input | 1 | 1: the whole line is inverted |
| cfg_data_inv | input | 1 | 1: only the data and parity bits are inverted |
| rx_word | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| rx_parity_err | output | 1 | Parity mismatch for the current word |
| rx_frame_err | output | 1 | Stop bit sampled low for the current word |

## Verification
The assertions assume that the divisor and the parity mode stay fixed while the bench runs and that the divisor is at least 4. That is why they can require two valid strobes to lie at least six bit periods apart: no legal frame is shorter. The stimulus keeps to this: the divisor is constant, and format and inversion settings change only while the line idles for at least a bit period. Frames are driven at exact bit durations, so back-to-back frames land on the receiver's stop-length boundary exactly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int UART_MAX_BITS = 9;
    localparam int UART_MIN_BITS = 5;
    localparam int UART_LEN_W    = $clog2(UART_MAX_BITS + 1);

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } parity_e;

    typedef enum logic [1:0] {
        STOP_HALF     = 2'd0,
        STOP_ONE      = 2'd1,
        STOP_ONE_HALF = 2'd2,
        STOP_TWO      = 2'd3
    } stop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2,
        S_TAIL
    } rx_state_e;

    typedef struct packed {
        logic [UART_MAX_BITS-1:0] word;
        logic                     par_err;
        logic                     frm_err;
    } rx_result_t;

    // ones_acc is the XOR of all data bits; pbit is the received parity bit.
    function automatic logic parity_ok(parity_e mode, logic ones_acc, logic pbit);
        case (mode)
            PAR_ODD:   return (ones_acc ^ pbit);
            PAR_EVEN:  return !(ones_acc ^ pbit);
            PAR_MARK:  return pbit;
            PAR_SPACE: return !pbit;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic logic uses_parity(parity_e mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN) ||
               (mode == PAR_MARK) || (mode == PAR_SPACE);
    endfunction

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_line,
    input  logic line_inv,
    output logic lvl,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= rx_line;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Normalised level: 1 is idle / stop level whatever the line polarity.
    assign lvl = sync_q[SYNC_STAGES-1] ^ line_inv;

    // prev_q resets to 0 so a start is only seen after idle has been observed.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Loading N-1 makes expire act N cycles after the load.
    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/uart_rx_assembler.sv
module uart_rx_assembler
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = UART_MAX_BITS,
    parameter int LEN_W  = UART_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              msb_first,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] word,
    output logic              ones_acc
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] keep_mask;
    logic [LEN_W-1:0]  shamt;
    logic              acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh_q  <= '0;
            acc_q <= 1'b0;
        end else if (shift_en) begin
            acc_q <= acc_q ^ bit_in;
            if (msb_first) sh_q <= {sh_q[DATA_W-2:0], bit_in};
            else           sh_q <= {bit_in, sh_q[DATA_W-1:1]};
        end
    end

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_mask
            assign keep_mask[i] = (len > LEN_W'(i));
        end
    endgenerate

    // LSB-first fills from the top, so the word sits in the upper len bits.
    assign shamt    = FULL_LEN - len;
    assign word     = msb_first ? (sh_q & keep_mask) : (sh_q >> shamt);
    assign ones_acc = acc_q;

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int CPB_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_line,
    input  logic [CPB_W-1:0]         cfg_clks_per_bit,
    input  logic [UART_LEN_W-1:0]    cfg_data_len,
    input  logic [2:0]               cfg_parity,
    input  logic [1:0]               cfg_stop,
    input  logic                     cfg_msb_first,
    input  logic                     cfg_line_inv,
    input  logic                     cfg_data_inv,
    output logic [UART_MAX_BITS-1:0] rx_word,
    output logic                     rx_valid,
    output logic                     rx_parity_err,
    output logic                     rx_frame_err
);

    localparam int CNT_W = CPB_W + 1;
    localparam logic [UART_LEN_W-1:0] LEN_MIN = UART_LEN_W'(UART_MIN_BITS);
    localparam logic [UART_LEN_W-1:0] LEN_MAX = UART_LEN_W'(UART_MAX_BITS);

    function automatic logic [CNT_W-1:0] less1(input logic [CNT_W-1:0] x);
        return (x == '0) ? '0 : (x - CNT_W'(1));
    endfunction

    logic                     lvl, fall, expire, load;
    logic [CNT_W-1:0]         load_val;
    logic [CNT_W-1:0]         t_full, t_half, t_qtr;
    logic [CNT_W-1:0]         start_wait, bit_wait, stop_wait, tail_wait;
    rx_state_e                state_q, state_d;
    logic [UART_LEN_W-1:0]    bit_cnt_q, len_eff;
    logic                     clr, shift_en, fire;
    logic                     perr_q, ferr_q, perr_set, ferr_set;
    logic                     data_bit, ones_acc;
    logic [UART_MAX_BITS-1:0] asm_word;
    parity_e                  par_mode;
    stop_e                    stop_mode;
    rx_result_t               res_q;
    logic                     valid_q;

    assign par_mode  = parity_e'(cfg_parity);
    assign stop_mode = stop_e'(cfg_stop);
    assign len_eff   = (cfg_data_len < LEN_MIN) ? LEN_MIN :
                       (cfg_data_len > LEN_MAX) ? LEN_MAX : cfg_data_len;

    uart_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .rx_line  (rx_line),
        .line_inv (cfg_line_inv),
        .lvl      (lvl),
        .fall     (fall)
    );

    uart_rx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expire   (expire)
    );

    assign data_bit = lvl ^ cfg_data_inv;

    uart_rx_assembler #(.DATA_W(UART_MAX_BITS), .LEN_W(UART_LEN_W)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .clear     (clr),
        .shift_en  (shift_en),
        .bit_in    (data_bit),
        .msb_first (cfg_msb_first),
        .len       (len_eff),
        .word      (asm_word),
        .ones_acc  (ones_acc)
    );

    // Interval lengths, all derived from the divisor.
    assign t_full     = {1'b0, cfg_clks_per_bit};
    assign t_half     = t_full >> 1;
    assign t_qtr      = t_full >> 2;
    assign start_wait = less1(t_half);
    assign bit_wait   = less1(t_full);

    // From the last data/parity centre to the first stop centre.
    always_comb begin
        case (stop_mode)
            STOP_HALF:     stop_wait = less1(t_half + t_qtr);
            STOP_ONE_HALF: stop_wait = less1(t_full + t_qtr);
            default:       stop_wait = bit_wait;
        endcase
    end

    // From the final stop centre to the end of the stop duration.
    always_comb begin
        case (stop_mode)
            STOP_HALF:     tail_wait = less1(t_qtr);
            STOP_ONE_HALF: tail_wait = less1(t_half + t_qtr);
            default:       tail_wait = less1(t_half);
        endcase
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = bit_wait;
        clr      = 1'b0;
        shift_en = 1'b0;
        fire     = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (fall) begin
                    state_d  = S_START;
                    load     = 1'b1;
                    load_val = start_wait;
                    clr      = 1'b1;
                end
            end
            S_START: begin
                if (expire) begin
                    if (lvl) begin
                        state_d = S_IDLE;
                    end else begin
                        state_d  = S_DATA;
                        load     = 1'b1;
                        load_val = bit_wait;
                    end
                end
            end
            S_DATA: begin
                if (expire) begin
                    shift_en = 1'b1;
                    load     = 1'b1;
                    if (bit_cnt_q == (len_eff - UART_LEN_W'(1))) begin
                        if (uses_parity(par_mode)) begin
                            state_d  = S_PARITY;
                            load_val = bit_wait;
                        end else begin
                            state_d  = S_STOP1;
                            load_val = stop_wait;
                        end
                    end else begin
                        load_val = bit_wait;
                    end
                end
            end
            S_PARITY: begin
                if (expire) begin
                    state_d  = S_STOP1;
                    load     = 1'b1;
                    load_val = stop_wait;
                end
            end
            S_STOP1: begin
                if (expire) begin
                    load = 1'b1;
                    if (stop_mode == STOP_TWO) begin
                        state_d  = S_STOP2;
                        load_val = bit_wait;
                    end else begin
                        state_d  = S_TAIL;
                        load_val = tail_wait;
                        fire     = 1'b1;
                    end
                end
            end
            S_STOP2: begin
                if (expire) begin
                    state_d  = S_TAIL;
                    load     = 1'b1;
                    load_val = tail_wait;
                    fire     = 1'b1;
                end
            end
            S_TAIL: begin
                if (expire) begin
                    if (fall) begin
                        state_d  = S_START;
                        load     = 1'b1;
                        load_val = start_wait;
                        clr      = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign perr_set = (state_q == S_PARITY) && expire &&
                      !parity_ok(par_mode, ones_acc, data_bit);
    assign ferr_set = ((state_q == S_STOP1) || (state_q == S_STOP2)) && expire && !lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            bit_cnt_q <= '0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            res_q     <= '0;
            valid_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= fire;
            if (clr)           bit_cnt_q <= '0;
            else if (shift_en) bit_cnt_q <= bit_cnt_q + UART_LEN_W'(1);
            if (clr)           perr_q <= 1'b0;
            else if (perr_set) perr_q <= 1'b1;
            if (clr)           ferr_q <= 1'b0;
            else if (ferr_set) ferr_q <= 1'b1;
            if (fire) begin
                res_q.word    <= asm_word;
                res_q.par_err <= perr_q;
                res_q.frm_err <= ferr_q | ~lvl;
            end
        end
    end

    assign rx_word       = res_q.word;
    assign rx_parity_err = res_q.par_err;
    assign rx_frame_err  = res_q.frm_err;
    assign rx_valid      = valid_q;

endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk
    import uart_rx_pkg::*;
#(
    parameter int CPB_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [CPB_W-1:0]         cfg_clks_per_bit,
    input logic [2:0]               cfg_parity,
    input logic                     rx_valid,
    input logic [UART_MAX_BITS-1:0] rx_word,
    input logic                     rx_parity_err,
    input logic                     rx_frame_err
);

    logic [31:0] since_q;
    logic        seen_q;
    logic [31:0] gap_min;

    assign gap_min = 32'(cfg_clks_per_bit) * 32'd6;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (rx_valid) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + 32'd1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!rx_valid && rx_word == '0 && !rx_parity_err && !rx_frame_err));

    assert_valid_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_word_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(rx_word) || !$stable(rx_parity_err) || !$stable(rx_frame_err)) |-> rx_valid);

    assert_no_parity_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_parity == 3'd0) |-> !rx_parity_err);

    assert_frame_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && seen_q) |-> (since_q >= gap_min));

endmodule

bind uart_frame_rx uart_frame_rx_chk #(.CPB_W(CPB_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .cfg_clks_per_bit (cfg_clks_per_bit),
    .cfg_parity       (cfg_parity),
    .rx_valid         (rx_valid),
    .rx_word          (rx_word),
    .rx_parity_err    (rx_parity_err),
    .rx_frame_err     (rx_frame_err)
);

// File: tb/uart_frame_rx_tb.sv
`timescale 1ns/1ps
module uart_frame_rx_tb;

    localparam int CPB = 16;
    localparam int WD  = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [15:0] cfg_cpb = 16'(CPB);
    logic [3:0] cfg_len = 4'd8;
    logic [2:0] cfg_par = 3'd0;
    logic [1:0] cfg_stp = 2'd1;
    logic       cfg_msb = 1'b0;
    logic       linv = 1'b0;
    logic       dinv = 1'b0;
    logic [8:0] rx_word;
    logic       rx_valid, rx_parity_err, rx_frame_err;

    int errors = 0;
    int checks = 0;
    int vcount = 0;
    int wide_cnt = 0;
    bit done = 0;
    logic [8:0] cap_word = '0;
    logic cap_pe = 1'b0, cap_fe = 1'b0, prev_v = 1'b0;

    always #5 clk = ~clk;

    uart_frame_rx u_dut (
        .clk              (clk),
        .rst              (rst),
        .rx_line          (rx_line),
        .cfg_clks_per_bit (cfg_cpb),
        .cfg_data_len     (cfg_len),
        .cfg_parity       (cfg_par),
        .cfg_stop         (cfg_stp),
        .cfg_msb_first    (cfg_msb),
        .cfg_line_inv     (linv),
        .cfg_data_inv     (dinv),
        .rx_word          (rx_word),
        .rx_valid         (rx_valid),
        .rx_parity_err    (rx_parity_err),
        .rx_frame_err     (rx_frame_err)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount   <= vcount + 1;
            cap_word <= rx_word;
            cap_pe   <= rx_parity_err;
            cap_fe   <= rx_frame_err;
            if (prev_v) wide_cnt <= wide_cnt + 1;
        end
        prev_v <= rx_valid;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int n);
        rx_line = v ^ linv;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int len, input int par,
                              input int stop, input bit msb, input bit bad_par,
                              input logic [1:0] bad_stop, input int gap, input string tag);
        logic [8:0]  ew;
        logic        pbit;
        logic [10:0] exp_r, act_r;
        int          v0;
        cfg_len = 4'(len);
        cfg_par = 3'(par);
        cfg_stp = 2'(stop);
        cfg_msb = msb;
        drive(1'b1, gap * CPB);
        v0 = vcount;
        ew = d & ((9'h1 << len) - 9'h1);
        drive(1'b0, CPB);
        for (int i = 0; i < len; i++)
            drive((msb ? d[len-1-i] : d[i]) ^ dinv, CPB);
        case (par)
            1: pbit = ~(^ew);
            2: pbit = ^ew;
            3: pbit = 1'b1;
            default: pbit = 1'b0;
        endcase
        if (par != 0) drive((pbit ^ bad_par) ^ dinv, CPB);
        case (stop)
            0: drive(~bad_stop[0], CPB / 2);
            1: drive(~bad_stop[0], CPB);
            2: drive(~bad_stop[0], (CPB * 3) / 2);
            default: begin
                drive(~bad_stop[0], CPB);
                drive(~bad_stop[1], CPB);
            end
        endcase
        exp_r = {ew, bad_par && (par != 0), (stop == 3) ? (|bad_stop) : bad_stop[0]};
        act_r = {cap_word, cap_pe, cap_fe};
        check(vcount == v0 + 1, tag, "valid count", longint'(vcount - v0), 1);
        check(act_r == exp_r, tag, "word/perr/ferr", act_r, exp_r);
    endtask

    task automatic set_inv(input logic l, input logic dv);
        linv = l;
        dinv = dv;
        drive(1'b1, 3 * CPB);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WD, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int k = 0;
        int v0;
        logic [8:0] held;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!rx_valid && rx_word == '0 && !rx_parity_err && !rx_frame_err,
              "R1", "reset outputs", {rx_word, rx_valid, rx_parity_err, rx_frame_err}, 0);
        rst = 1'b0;
        drive(1'b1, 2 * CPB);
        check(vcount == 0 && rx_word == '0, "R1", "idle after reset", vcount, 0);

        // R2 / R3: sweep length, parity, stop and order with good frames
        for (int len = 5; len <= 9; len++)
            for (int par = 0; par <= 4; par++)
                for (int stp = 0; stp <= 3; stp++)
                    for (int m = 0; m <= 1; m++) begin
                        send_frame(9'(k * 37 + 11), len, par, stp, m[0], 1'b0, 2'b00, 1,
                                   m ? "R3" : "R2");
                        k++;
                    end

        // R4 odd / even parity errors
        for (int len = 5; len <= 9; len++)
            for (int par = 1; par <= 2; par++)
                for (int b = 0; b <= 1; b++)
                    send_frame(9'(len * 53 + par * 7 + b), len, par, 1, 1'b0, b[0], 2'b00, 1, "R4");

        // R5 mark / space and none
        for (int par = 3; par <= 4; par++)
            for (int b = 0; b <= 1; b++)
                send_frame(9'h0A5 + 9'(par), 8, par, 1, 1'b0, b[0], 2'b00, 1, "R5");
        send_frame(9'h1FF, 9, 0, 1, 1'b0, 1'b0, 2'b00, 1, "R5");

        // R6 back-to-back frames for every stop length
        for (int stp = 0; stp <= 3; stp++) begin
            send_frame(9'h055, 8, 2, stp, 1'b0, 1'b0, 2'b00, 2, "R6");
            for (int j = 0; j < 3; j++)
                send_frame(9'(j * 91 + 3), 8, 2, stp, 1'b0, 1'b0, 2'b00, 0, "R6");
        end

        // R7 framing errors
        for (int stp = 0; stp <= 2; stp++)
            send_frame(9'h03C, 7, 1, stp, 1'b0, 1'b0, 2'b01, 1, "R7");
        send_frame(9'h0C3, 8, 0, 3, 1'b0, 1'b0, 2'b01, 1, "R7");
        send_frame(9'h0C3, 8, 0, 3, 1'b0, 1'b0, 2'b10, 1, "R7");
        send_frame(9'h0C3, 8, 0, 3, 1'b0, 1'b0, 2'b00, 1, "R7");

        // R8 line inversion
        set_inv(1'b1, 1'b0);
        for (int j = 0; j < 4; j++)
            send_frame(9'(j * 71 + 5), 8, 2, 1, j[0], j[1], 2'b00, 1, "R8");
        send_frame(9'h011, 6, 0, 0, 1'b0, 1'b0, 2'b01, 1, "R8");

        // R9 data-only inversion, with and without line inversion
        for (int l = 0; l <= 1; l++) begin
            set_inv(l[0], 1'b1);
            for (int par = 1; par <= 4; par++)
                send_frame(9'(par * 29 + l), 8, par, 1, 1'b0, 1'b0, 2'b00, 1, "R9");
            send_frame(9'h0F0, 8, 3, 1, 1'b1, 1'b1, 2'b00, 1, "R9");
        end
        set_inv(1'b0, 1'b0);

        // R10 glitch rejection
        cfg_par = 3'd0; cfg_stp = 2'd1; cfg_len = 4'd8; cfg_msb = 1'b0;
        v0 = vcount;
        drive(1'b0, 5);
        drive(1'b1, 4 * CPB);
        check(vcount == v0, "R10", "no valid after glitch", vcount - v0, 0);
        send_frame(9'h081, 8, 0, 1, 1'b0, 1'b0, 2'b00, 1, "R10");

        // R11 one-cycle strobe and hold
        held = rx_word;
        v0 = vcount;
        drive(1'b1, 4 * CPB);
        check(rx_word == held && vcount == v0 && !rx_valid, "R11", "word held",
              rx_word, held);
        check(wide_cnt == 0, "R11", "valid wider than one cycle", wide_cnt, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule